// File: doc/BRIEF.md
# Banked Scratchpad Read Arbiter

This block is the read front end of a scratchpad split into word-interleaved banks. Sixteen parallel lanes present one group of word-address reads at once. Each address is steered to a bank by its low-order bits. The block finds the lanes that would collide inside a bank and spreads their reads over as few service rounds as the collisions allow. Each lane's data comes back on that lane's own response slot.

Two or more lanes that read the same word in the same bank are not a collision. They share one bank access and all receive the word in the same round. Only different words in one bank force extra rounds. Each bank access occupies its bank for two clock cycles, so every round lasts two cycles. The block holds `busy` high from acceptance until the last lane of the group has been answered, and it refuses new groups during that time. Bank contents are preloaded at reset with a fixed pattern, so the read path can be checked without a write port.

Top module: `spad_conflict_arb`

## Requirements
- R1: A word address A maps to bank A mod 16 (its low four bits) and to row A div 16 inside that bank. Reset loads every word A with the value 0xA5000000 + A*0x00010001 (32-bit). A lane's response data is the word at its own address.
- R2: If all valid lanes of a group target different banks, every lane's response arrives 2 cycles after the acceptance edge, and `busy` is low from that same edge.
- R3: The number of rounds for a group equals the largest count of distinct addresses that fall into any one bank. Responses of round r appear 2r cycles after the acceptance edge. `busy` falls at the edge that delivers the final round.
- R4: If every valid lane reads the same address, the group completes in one round and every lane receives that word.
- R5: Within a bank, addresses are served in the order of the lowest lane that requests each one. All lanes that share an address are answered in the same round.
- R6: A group is accepted only on an edge where `busy` is low and at least one `req_valid` bit is set. Requests presented while `busy` is high are ignored, and they produce no response at any later time.
- R7: Each valid lane of an accepted group receives exactly one `rsp_valid` pulse, and invalid lanes receive none. A group with no valid bits is not accepted.
- R8: Lane addresses base + k*s (k = lane index) finish in one round for s = 1 or any odd s. They take two rounds for s = 2 and eight rounds for s = 8.
- R9: During and directly after reset, `busy` and every `rsp_valid` bit are low.
- R10: A bank starts at most one read in any two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 16 | Per-lane request valid; bit k is lane k |
| req_addr | input | 128 | Lane word addresses; lane k in bits [8k+7:8k] |
| busy | output | 1 | High while a group is being served; new groups are refused |
| rsp_valid | output | 16 | One-cycle response pulse per lane |
| rsp_data | output | 512 | Lane data; lane k in bits [32k+31:32k], valid with its pulse |

## Verification
All timing is counted from the rising edge that accepts a group. A lane served in round r pulses `rsp_valid` on the edge 2r cycles later. `busy` drops on edge 2R, where R is the group's round count. The bench drives inputs and samples outputs on falling edges. It numbers each falling edge by how many rising edges have passed since acceptance. For every lane it computes the expected round from the bank and lowest-lane ordering rules, and it accepts a pulse only at edge 2r with the matching data. It then confirms that `busy` had the right value at every sample and that no lane pulsed twice.

// File: rtl/spad_pkg.sv
package spad_pkg;

    typedef enum logic {
        PH_ISSUE  = 1'b0,
        PH_RETURN = 1'b1
    } spad_phase_e;

    // Preload pattern for the word at global word address a.
    function automatic logic [31:0] spad_fill(input logic [31:0] a);
        return 32'hA500_0000 + a * 32'h0001_0001;
    endfunction

endpackage

// File: rtl/spad_bank_pick.sv
module spad_bank_pick #(
    parameter int LANES   = 16,
    parameter int AW      = 8,
    parameter int BANK_W  = 4,
    parameter int BANK_ID = 0,
    localparam int ROW_W  = AW - BANK_W
) (
    input  logic [LANES-1:0]         pend,
    input  logic [LANES-1:0][AW-1:0] addr,
    output logic [LANES-1:0]         grant,
    output logic                     rd_en,
    output logic [ROW_W-1:0]         rd_row
);

    logic          found;
    logic [AW-1:0] head;

    // Lowest pending lane in this bank sets the address for the round.
    always_comb begin
        found = 1'b0;
        head  = '0;
        for (int i = 0; i < LANES; i++) begin
            if (!found && pend[i] && addr[i][BANK_W-1:0] == BANK_W'(BANK_ID)) begin
                found = 1'b1;
                head  = addr[i];
            end
        end
        for (int j = 0; j < LANES; j++) begin
            grant[j] = found && pend[j] && (addr[j] == head);
        end
        rd_en  = found;
        rd_row = head[AW-1:BANK_W];
    end

endmodule

// File: rtl/spad_bank_mem.sv
module spad_bank_mem #(
    parameter int DW      = 32,
    parameter int ROW_W   = 4,
    parameter int BANK_W  = 4,
    parameter int BANK_ID = 0,
    localparam int ROWS   = 1 << ROW_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic [ROW_W-1:0] rd_row,
    output logic [DW-1:0]    rd_data
);
    import spad_pkg::*;

    logic [DW-1:0] mem_q [ROWS];
    logic [DW-1:0] rd_data_d, rd_data_q;

    always_comb begin
        rd_data_d = rd_en ? mem_q[rd_row] : rd_data_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++) begin
                mem_q[r] <= DW'(spad_fill(32'((r << BANK_W) | BANK_ID)));
            end
            rd_data_q <= '0;
        end else begin
            rd_data_q <= rd_data_d;
        end
    end

    assign rd_data = rd_data_q;

    // Two-cycle bank service time.
    p_bank_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> !rd_en);

endmodule

// File: rtl/spad_conflict_arb.sv
module spad_conflict_arb #(
    parameter int LANES = 16,
    parameter int BANKS = 16,
    parameter int AW    = 8,
    parameter int DW    = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [LANES-1:0]    req_valid,
    input  logic [LANES*AW-1:0] req_addr,
    output logic                busy,
    output logic [LANES-1:0]    rsp_valid,
    output logic [LANES*DW-1:0] rsp_data
);
    import spad_pkg::*;

    localparam int BANK_W = $clog2(BANKS);
    localparam int ROW_W  = AW - BANK_W;

    typedef struct packed {
        logic                     busy;
        spad_phase_e              phase;
        logic [LANES-1:0]         pend;
        logic [LANES-1:0][AW-1:0] addr;
        logic [LANES-1:0]         grant;
        logic [LANES-1:0]         rsp_valid;
        logic [LANES-1:0][DW-1:0] rsp_data;
    } arb_state_t;

    arb_state_t st_d, st_q;

    logic [BANKS-1:0][LANES-1:0] bank_grant;
    logic [BANKS-1:0]            bank_hit;
    logic [BANKS-1:0]            bank_en;
    logic [BANKS-1:0][ROW_W-1:0] bank_row;
    logic [BANKS-1:0][DW-1:0]    bank_rdata;
    logic [LANES-1:0]            grant_all;

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        spad_bank_pick #(
            .LANES(LANES), .AW(AW), .BANK_W(BANK_W), .BANK_ID(b)
        ) u_pick (
            .pend  (st_q.pend),
            .addr  (st_q.addr),
            .grant (bank_grant[b]),
            .rd_en (bank_hit[b]),
            .rd_row(bank_row[b])
        );

        assign bank_en[b] = bank_hit[b] && st_q.busy && (st_q.phase == PH_ISSUE);

        spad_bank_mem #(
            .DW(DW), .ROW_W(ROW_W), .BANK_W(BANK_W), .BANK_ID(b)
        ) u_mem (
            .clk    (clk),
            .rst_n  (rst_n),
            .rd_en  (bank_en[b]),
            .rd_row (bank_row[b]),
            .rd_data(bank_rdata[b])
        );
    end

    always_comb begin
        grant_all = '0;
        for (int b = 0; b < BANKS; b++) begin
            grant_all = grant_all | bank_grant[b];
        end
    end

    always_comb begin
        st_d           = st_q;
        st_d.rsp_valid = '0;
        if (!st_q.busy) begin
            if (|req_valid) begin
                st_d.busy  = 1'b1;
                st_d.phase = PH_ISSUE;
                st_d.pend  = req_valid;
                for (int j = 0; j < LANES; j++) begin
                    st_d.addr[j] = req_addr[j*AW +: AW];
                end
            end
        end else if (st_q.phase == PH_ISSUE) begin
            st_d.grant = grant_all;
            st_d.phase = PH_RETURN;
        end else begin
            for (int j = 0; j < LANES; j++) begin
                if (st_q.grant[j]) begin
                    st_d.rsp_valid[j] = 1'b1;
                    st_d.rsp_data[j]  = bank_rdata[st_q.addr[j][BANK_W-1:0]];
                end
            end
            st_d.pend  = st_q.pend & ~st_q.grant;
            st_d.grant = '0;
            st_d.phase = PH_ISSUE;
            if (st_d.pend == '0) begin
                st_d.busy = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy      = st_q.busy;
    assign rsp_valid = st_q.rsp_valid;
    assign rsp_data  = st_q.rsp_data;

    // A response only goes to a lane that was still waiting.
    p_rsp_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.rsp_valid & ~$past(st_q.pend)) == '0);

    // The final round's responses leave with the fall of busy.
    p_busy_end_rsp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.busy) |-> (|st_q.rsp_valid));

    // No lane joins a group that is already in service.
    p_no_join_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |=> ((st_q.pend & ~$past(st_q.pend)) == '0));

    // Idle means nothing is waiting.
    p_idle_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.busy |-> (st_q.pend == '0));

    // Addresses stay frozen across a group.
    p_addr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && $past(st_q.busy)) |-> $stable(st_q.addr));

endmodule

// File: tb/tb_spad_conflict_arb.sv
module tb_spad_conflict_arb;
    localparam int CLK_PERIOD = 10;
    localparam int L  = 16;
    localparam int AW = 8;
    localparam int DW = 32;

    typedef struct packed {
        logic [7:0]  base;
        logic [7:0]  stride;
        logic [15:0] mask;
        logic [7:0]  rounds;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{8'd0,   8'd1,  16'hFFFF, 8'd1},   // R2 linear
        '{8'd5,   8'd3,  16'hFFFF, 8'd1},   // R8 odd stride
        '{8'd0,   8'd2,  16'hFFFF, 8'd2},   // R8 stride 2
        '{8'd0,   8'd8,  16'hFFFF, 8'd8},   // R8 stride 8
        '{8'd7,   8'd0,  16'hFFFF, 8'd1},   // R4 broadcast
        '{8'd3,   8'd16, 16'hFFFF, 8'd16},  // R3 one bank, 16 words
        '{8'd1,   8'd1,  16'h00A5, 8'd1},   // R7 sparse lanes
        '{8'd200, 8'd5,  16'hFFFF, 8'd1}    // R1 address wrap
    };

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [L-1:0]        req_valid = '0;
    logic [L*AW-1:0]     req_addr = '0;
    logic                busy;
    logic [L-1:0]        rsp_valid;
    logic [L*DW-1:0]     rsp_data;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spad_conflict_arb dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .busy(busy), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    function automatic logic [31:0] exp_word(input logic [7:0] a);
        return 32'hA500_0000 + {24'd0, a} * 32'h0001_0001;
    endfunction

    task automatic chk(input bit ok, input string rq, input longint act,
                       input longint expv, input string what);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, expv);
        end
    endtask

    // intrude: push a foreign group while busy, then withdraw it (R6).
    task automatic run_group(input logic [L-1:0][AW-1:0] a, input logic [L-1:0] m,
                             input int table_rounds, input string rq, input bit intrude);
        int rnd [L];
        int got [L];
        int maxr = 0;
        int busy_err = 0;
        int last_c;
        for (int j = 0; j < L; j++) begin
            rnd[j] = 0;
            got[j] = 0;
            if (m[j]) begin
                int first = j;
                for (int i = j - 1; i >= 0; i--)
                    if (m[i] && a[i] == a[j]) first = i;
                rnd[j] = 1;
                for (int i = 0; i < first; i++) begin
                    bit lead = 1'b1;
                    for (int k = 0; k < i; k++)
                        if (m[k] && a[k] == a[i]) lead = 1'b0;
                    if (m[i] && lead && a[i][3:0] == a[j][3:0] && a[i] != a[j])
                        rnd[j]++;
                end
                if (rnd[j] > maxr) maxr = rnd[j];
            end
        end
        chk(maxr == table_rounds, rq, maxr, table_rounds, "round count of pattern (R3)");
        while (busy) @(negedge clk);
        req_valid = m;
        for (int j = 0; j < L; j++) req_addr[j*AW +: AW] = a[j];
        @(posedge clk);
        @(negedge clk);
        req_valid = '0;
        last_c = 2 * maxr + 4;
        for (int c = 1; c <= last_c; c++) begin
            @(posedge clk);
            @(negedge clk);
            if (busy != (c < 2 * maxr)) busy_err++;
            for (int j = 0; j < L; j++) begin
                if (rsp_valid[j]) begin
                    got[j]++;
                    chk(m[j] && c == 2 * rnd[j], rq, c, 2 * rnd[j],
                        $sformatf("lane %0d response cycle (R5 R10)", j));
                    chk(rsp_data[j*DW +: DW] == exp_word(a[j]), rq,
                        rsp_data[j*DW +: DW], exp_word(a[j]),
                        $sformatf("lane %0d data (R1)", j));
                end
            end
            if (intrude && c == 2) begin
                req_valid = '1;
                for (int j = 0; j < L; j++) req_addr[j*AW +: AW] = AW'(8'h80 + j);
            end
            if (intrude && c == 10) req_valid = '0;
        end
        chk(busy_err == 0, rq, busy_err, 0, "busy profile mismatches (R3 R6)");
        for (int j = 0; j < L; j++)
            chk(got[j] == (m[j] ? 1 : 0), rq, got[j], m[j] ? 1 : 0,
                $sformatf("lane %0d response count (R7)", j));
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [L-1:0][AW-1:0] a;
        // R9: reset state
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R9", busy, 0, "busy in reset");
        chk(rsp_valid == '0, "R9", rsp_valid, 0, "rsp_valid in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0 && rsp_valid == '0, "R9", {busy, rsp_valid}, 0, "after reset");

        // Table walk
        for (int v = 0; v < 8; v++) begin
            for (int j = 0; j < L; j++)
                a[j] = AW'(VECS[v].base + VECS[v].stride * j);
            run_group(a, VECS[v].mask, int'(VECS[v].rounds),
                      $sformatf("R2 R3 R4 R8 vec%0d", v), 1'b0);
        end

        // R5: ordering and sharing inside banks
        a = '0;
        a[0] = 8'h10; a[1] = 8'h20; a[2] = 8'h10; a[3] = 8'h30;
        a[4] = 8'h20; a[5] = 8'h01; a[6] = 8'h11;
        run_group(a, 16'h007F, 3, "R5", 1'b0);

        // R6: intruding requests while busy are ignored
        for (int j = 0; j < L; j++) a[j] = AW'(3 + 16 * j);
        run_group(a, 16'hFFFF, 16, "R6", 1'b1);

        // R7: empty group is not accepted
        run_group(a, 16'h0000, 0, "R7", 1'b0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule